// File: doc/BRIEF.md
# Digital Potentiometer Wiper Register Bank

This block holds the register state for a group of digitally controlled potentiometer channels. Every channel owns one wiper register and a small set of preset registers. The wiper register's value picks the resistor tap: 0x00 puts the wiper at the low-terminal end and 0xFF puts it at the high-terminal end. A preset can be copied into the wiper in one step. The wiper can also be saved back into a preset, written directly, or moved one tap at a time. The serial bus front end, the resistor string and non-volatile storage timing all sit outside this block. The presets are ordinary flops.

Commands enter through a valid/ready port. A command is accepted on any clock edge where `cmd_valid` and `cmd_ready` are both high, and it takes effect on that edge. Read results leave through a valid/ready response port. `cmd_ready` drops only while a read result is waiting and `rsp_ready` is low. This back-pressure keeps a pending result from being overwritten. An active-low protect input blocks every change to the preset registers but still allows wiper operations.

Top module: `dpot_regbank`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, every preset register reads 0x80. Every wiper register holds the reset value of its channel's preset 0 (0x80). `rsp_valid` and `wp_err` are 0 and `cmd_ready` is 1.
- R2: An accepted command with opcode 3'b001, while `wp_n` is high, writes `cmd_data` into preset `cmd_dr` of channel `cmd_ch`. The new value is visible one cycle later.
- R3: An accepted command with opcode 3'b011 loads `cmd_data` into the wiper of channel `cmd_ch`, whatever the level of `wp_n`.
- R4: An accepted command with opcode 3'b100 copies preset `cmd_dr` of channel `cmd_ch` into that channel's wiper, whatever the level of `wp_n`.
- R5: An accepted command with opcode 3'b101, while `wp_n` is high, copies the wiper of channel `cmd_ch` into that channel's preset `cmd_dr`.
- R6: Opcode 3'b110 raises the selected wiper by one and opcode 3'b111 lowers it by one. A wiper at 0xFF stays at 0xFF when raised, and a wiper at 0x00 stays at 0x00 when lowered.
- R7: While `wp_n` is low, opcodes 3'b001 and 3'b101 change no register, and `wp_err` is high for exactly the one cycle after acceptance. `wp_err` is low at all other times.
- R8: An accepted opcode 3'b000 (read preset `cmd_dr`) or 3'b010 (read wiper) sets `rsp_valid` in the next cycle, with `rsp_data` holding the register value from the accepting edge.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged and `cmd_ready` is low. A command offered at that time is not taken. When `rsp_ready` is high and no new read is accepted, `rsp_valid` falls one cycle later.
- R10: A command changes only the register it addresses. Preset r of channel c appears on `dr_flat[(c*4+r)*8 +: 8]`, and the wiper of channel c appears on `wiper_pos[c*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wp_n | input | 1 | Preset write protect, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_ch | input | 2 | Channel select |
| cmd_dr | input | 2 | Preset register select |
| cmd_op | input | 3 | Opcode |
| cmd_data | input | 8 | Write data |
| rsp_valid | output | 1 | Read result available |
| rsp_ready | input | 1 | Consumer takes read result |
| rsp_data | output | 8 | Read result |
| wp_err | output | 1 | One-cycle pulse for a blocked preset write |
| wiper_pos | output | 32 | All wiper registers, channel 0 in the low byte |
| dr_flat | output | 128 | All preset registers |

## Verification
Several properties are checked on every cycle: response holding under back-pressure, the read latency of one cycle, the cause of every `wp_err` pulse, preset stability during a blocked write, and saturating single steps of the wiper. The contents of the registers after arbitrary mixes of writes, loads and stores can only be compared against the bench's model. The same holds for the independence of channels and for the refusal of commands while `cmd_ready` is low.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  typedef enum logic [2:0] {
    OP_RD_DR  = 3'd0,
    OP_WR_DR  = 3'd1,
    OP_RD_WCR = 3'd2,
    OP_WR_WCR = 3'd3,
    OP_LOAD   = 3'd4,
    OP_STORE  = 3'd5,
    OP_UP     = 3'd6,
    OP_DN     = 3'd7
  } dpot_op_e;

  typedef struct packed {
    logic wr_dr;
    logic wr_wcr;
    logic load;
    logic store;
    logic up;
    logic dn;
  } dpot_ctl_t;
endpackage

// File: rtl/dpot_cmd_decode.sv
module dpot_cmd_decode
  import dpot_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              accept,
  input  logic              wp_n,
  input  logic [2:0]        op,
  input  logic [CH_W-1:0]   ch,
  output dpot_ctl_t         ctl,
  output logic [NUM_CH-1:0] ch_hit,
  output logic              rd_req,
  output logic              rd_is_wcr,
  output logic              blocked
);
  dpot_op_e op_e;
  assign op_e = dpot_op_e'(op);

  always_comb begin
    ctl       = '0;
    rd_req    = 1'b0;
    rd_is_wcr = 1'b0;
    blocked   = 1'b0;
    if (accept) begin
      unique case (op_e)
        OP_RD_DR:  rd_req = 1'b1;
        OP_RD_WCR: begin rd_req = 1'b1; rd_is_wcr = 1'b1; end
        OP_WR_DR:  if (wp_n) ctl.wr_dr = 1'b1; else blocked = 1'b1;
        OP_STORE:  if (wp_n) ctl.store = 1'b1; else blocked = 1'b1;
        OP_WR_WCR: ctl.wr_wcr = 1'b1;
        OP_LOAD:   ctl.load   = 1'b1;
        OP_UP:     ctl.up     = 1'b1;
        OP_DN:     ctl.dn     = 1'b1;
        default:   ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign ch_hit[i] = (ch == CH_W'(i));
  end
endmodule

// File: rtl/dpot_channel.sv
module dpot_channel
  import dpot_pkg::*;
#(
  parameter int NUM_DR = 4,
  parameter int W = 8,
  parameter int unsigned RST_VAL = 'h80,
  localparam int DR_W = $clog2(NUM_DR)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel,
  input  dpot_ctl_t           ctl,
  input  logic [DR_W-1:0]     dr_idx,
  input  logic [W-1:0]        din,
  output logic [NUM_DR*W-1:0] dr_q,
  output logic [W-1:0]        wcr_q
);
  localparam logic [W-1:0] INIT = W'(RST_VAL);
  localparam logic [W-1:0] TOP  = '1;

  logic [W-1:0] dr [NUM_DR];
  logic [W-1:0] wcr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_DR; k++) dr[k] <= INIT;
      wcr <= INIT;  // wiper follows preset 0's reset value
    end else if (sel) begin
      if (ctl.wr_dr) dr[dr_idx] <= din;
      if (ctl.store) dr[dr_idx] <= wcr;
      if (ctl.wr_wcr) wcr <= din;
      if (ctl.load) wcr <= dr[dr_idx];
      if (ctl.up && wcr != TOP) wcr <= wcr + 1'b1;
      if (ctl.dn && wcr != '0) wcr <= wcr - 1'b1;
    end
  end

  for (genvar r = 0; r < NUM_DR; r++) begin : g_out
    assign dr_q[r*W +: W] = dr[r];
  end
  assign wcr_q = wcr;
endmodule

// File: rtl/dpot_regbank.sv
module dpot_regbank
  import dpot_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_DR = 4,
  parameter int W = 8,
  parameter int unsigned RST_VAL = 'h80,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int DR_W = $clog2(NUM_DR)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wp_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [CH_W-1:0]            cmd_ch,
  input  logic [DR_W-1:0]            cmd_dr,
  input  logic [2:0]                 cmd_op,
  input  logic [W-1:0]               cmd_data,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [W-1:0]               rsp_data,
  output logic                       wp_err,
  output logic [NUM_CH*W-1:0]        wiper_pos,
  output logic [NUM_CH*NUM_DR*W-1:0] dr_flat
);
  logic              accept, rd_req, rd_is_wcr, blocked;
  logic [NUM_CH-1:0] ch_hit;
  dpot_ctl_t         ctl;
  logic [W-1:0]      rd_val;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;

  dpot_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .accept    (accept),
    .wp_n      (wp_n),
    .op        (cmd_op),
    .ch        (cmd_ch),
    .ctl       (ctl),
    .ch_hit    (ch_hit),
    .rd_req    (rd_req),
    .rd_is_wcr (rd_is_wcr),
    .blocked   (blocked)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dpot_channel #(.NUM_DR(NUM_DR), .W(W), .RST_VAL(RST_VAL)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (ch_hit[c]),
      .ctl    (ctl),
      .dr_idx (cmd_dr),
      .din    (cmd_data),
      .dr_q   (dr_flat[c*NUM_DR*W +: NUM_DR*W]),
      .wcr_q  (wiper_pos[c*W +: W])
    );
  end

  always_comb begin
    if (rd_is_wcr) rd_val = wiper_pos[int'(cmd_ch)*W +: W];
    else           rd_val = dr_flat[(int'(cmd_ch)*NUM_DR + int'(cmd_dr))*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      wp_err    <= 1'b0;
    end else begin
      wp_err <= blocked;
      if (rd_req) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_val;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dpot_regbank_chk.sv
module dpot_regbank_chk
  import dpot_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int NUM_DR = 4,
  parameter int W = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wp_n,
  input logic                       cmd_valid,
  input logic                       cmd_ready,
  input logic [CH_W-1:0]            cmd_ch,
  input logic [2:0]                 cmd_op,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [W-1:0]               rsp_data,
  input logic                       wp_err,
  input logic [NUM_CH*W-1:0]        wiper_pos,
  input logic [NUM_CH*NUM_DR*W-1:0] dr_flat
);
  logic acc, is_rd, is_prot;
  assign acc     = cmd_valid && cmd_ready;
  assign is_rd   = (cmd_op == OP_RD_DR) || (cmd_op == OP_RD_WCR);
  assign is_prot = (cmd_op == OP_WR_DR) || (cmd_op == OP_STORE);

  logic            up_d, dn_d;
  logic [CH_W-1:0] ch_d;
  logic [W-1:0]    wv_d, cur_w, now_w;
  assign cur_w = wiper_pos[int'(cmd_ch)*W +: W];
  assign now_w = wiper_pos[int'(ch_d)*W +: W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_d <= 1'b0; dn_d <= 1'b0; ch_d <= '0; wv_d <= '0;
    end else begin
      up_d <= acc && (cmd_op == OP_UP);
      dn_d <= acc && (cmd_op == OP_DN);
      ch_d <= cmd_ch;
      wv_d <= cur_w;
    end
  end

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_rd_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_rd |=> rsp_valid);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && !wp_n && is_prot) |=> !wp_err);

  assert_prot_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !wp_n && is_prot |=> $stable(dr_flat) && wp_err);

  assert_step_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up_d |-> now_w == ((wv_d == {W{1'b1}}) ? wv_d : W'(wv_d + 1'b1)));

  assert_step_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_d |-> now_w == ((wv_d == '0) ? wv_d : W'(wv_d - 1'b1)));
endmodule

bind dpot_regbank dpot_regbank_chk #(.NUM_CH(NUM_CH), .NUM_DR(NUM_DR), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_ch(cmd_ch), .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .wp_err(wp_err), .wiper_pos(wiper_pos), .dr_flat(dr_flat)
);

// File: tb/dpot_regbank_test.sv
module dpot_regbank_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, wp_n, cmd_valid, cmd_ready, rsp_valid, rsp_ready, wp_err;
  logic [1:0]   cmd_ch, cmd_dr;
  logic [2:0]   cmd_op;
  logic [7:0]   cmd_data, rsp_data;
  logic [31:0]  wiper_pos;
  logic [127:0] dr_flat;

  dpot_regbank uut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_ch(cmd_ch), .cmd_dr(cmd_dr), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .wp_err(wp_err),
    .wiper_pos(wiper_pos), .dr_flat(dr_flat)
  );

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] m_dr [4][4];
  logic [7:0] m_wcr [4];
  logic       m_rv;
  logic [7:0] m_rdata;

  task automatic check(input string req, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_dr_flat();
    logic [127:0] f;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) f[(c*4+r)*8 +: 8] = m_dr[c][r];
    return f;
  endfunction

  function automatic logic [31:0] exp_wiper();
    logic [31:0] f;
    for (int c = 0; c < 4; c++) f[c*8 +: 8] = m_wcr[c];
    return f;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd1: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6, 3'd7: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic step(input bit v, input logic [1:0] ch, input logic [1:0] dr,
                      input logic [2:0] op, input logic [7:0] d, input bit rr, input bit wp);
    bit acc, rd, err_e;
    logic [7:0] rv;
    cmd_valid = v; cmd_ch = ch; cmd_dr = dr; cmd_op = op; cmd_data = d;
    rsp_ready = rr; wp_n = wp;
    @(posedge clk);
    @(negedge clk);
    acc = v && (!m_rv || rr);
    rd = 1'b0; err_e = 1'b0; rv = '0;
    if (acc) begin
      case (op)
        3'd0: begin rd = 1'b1; rv = m_dr[ch][dr]; end
        3'd2: begin rd = 1'b1; rv = m_wcr[ch]; end
        3'd1: if (wp) m_dr[ch][dr] = d; else err_e = 1'b1;
        3'd5: if (wp) m_dr[ch][dr] = m_wcr[ch]; else err_e = 1'b1;
        3'd3: m_wcr[ch] = d;
        3'd4: m_wcr[ch] = m_dr[ch][dr];
        3'd6: if (m_wcr[ch] != 8'hFF) m_wcr[ch] = m_wcr[ch] + 8'd1;
        default: if (m_wcr[ch] != 8'h00) m_wcr[ch] = m_wcr[ch] - 8'd1;
      endcase
    end
    if (rd) begin m_rv = 1'b1; m_rdata = rv; end
    else if (rr) m_rv = 1'b0;
    check({tag_of(op), " R10"}, "presets", dr_flat, exp_dr_flat());
    check({tag_of(op), " R10"}, "wipers", {96'd0, wiper_pos}, {96'd0, exp_wiper()});
    check("R8 R9", "rsp_valid", {127'd0, rsp_valid}, {127'd0, m_rv});
    if (m_rv) check("R8 R9", "rsp_data", {120'd0, rsp_data}, {120'd0, m_rdata});
    check("R7", "wp_err", {127'd0, wp_err}, {127'd0, err_e});
    check("R9", "cmd_ready", {127'd0, cmd_ready}, {127'd0, (!m_rv || rr)});
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R9: actual hung expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wp_n = 1'b1; cmd_valid = 1'b0; cmd_ch = '0; cmd_dr = '0;
    cmd_op = '0; cmd_data = '0; rsp_ready = 1'b1;
    for (int c = 0; c < 4; c++) begin
      m_wcr[c] = 8'h80;
      for (int r = 0; r < 4; r++) m_dr[c][r] = 8'h80;
    end
    m_rv = 1'b0; m_rdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "presets", dr_flat, exp_dr_flat());
    check("R1", "wipers", {96'd0, wiper_pos}, {96'd0, exp_wiper()});
    check("R1", "rsp_valid", {127'd0, rsp_valid}, 128'd0);
    check("R1", "wp_err", {127'd0, wp_err}, 128'd0);
    check("R1", "cmd_ready", {127'd0, cmd_ready}, 128'd1);
    rst_n = 1'b1;

    // R2 then R4
    step(1, 2'd2, 2'd3, 3'd1, 8'h3C, 1, 1);
    step(1, 2'd2, 2'd3, 3'd4, 8'h00, 1, 1);
    // R6 saturation at top and bottom
    step(1, 2'd1, 2'd0, 3'd3, 8'hFF, 1, 1);
    step(1, 2'd1, 2'd0, 3'd6, 8'h00, 1, 1);
    step(1, 2'd1, 2'd0, 3'd7, 8'h00, 1, 1);
    step(1, 2'd0, 2'd0, 3'd3, 8'h00, 1, 1);
    step(1, 2'd0, 2'd0, 3'd7, 8'h00, 1, 1);
    step(1, 2'd0, 2'd0, 3'd6, 8'h00, 1, 1);
    // R7: protect blocks presets, wiper operations still act
    step(1, 2'd3, 2'd1, 3'd1, 8'h55, 1, 0);
    step(1, 2'd1, 2'd2, 3'd5, 8'h00, 1, 0);
    step(1, 2'd3, 2'd1, 3'd3, 8'h12, 1, 0);
    step(1, 2'd3, 2'd1, 3'd6, 8'h00, 1, 0);
    step(1, 2'd3, 2'd1, 3'd0, 8'h00, 1, 0);
    // R5 store with protect off
    step(1, 2'd1, 2'd2, 3'd5, 8'h00, 1, 1);
    step(1, 2'd1, 2'd2, 3'd0, 8'h00, 1, 1);
    // R9 back-pressure
    step(1, 2'd2, 2'd3, 3'd0, 8'h00, 0, 1);
    step(1, 2'd0, 2'd0, 3'd1, 8'hAA, 0, 1);
    step(1, 2'd1, 2'd0, 3'd2, 8'h00, 0, 1);
    step(0, 2'd0, 2'd0, 3'd0, 8'h00, 1, 1);
    step(0, 2'd0, 2'd0, 3'd0, 8'h00, 1, 1);

    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 8) != 0, 2'($urandom), 2'($urandom), 3'($urandom),
           (($urandom % 4) == 0) ? 8'hFF : 8'($urandom),
           ($urandom % 4) != 0, ($urandom % 5) != 0);
    end
    summary();
  end
endmodule